// File: doc/BRIEF.md
# Processor Reset Qualifier and Boot Vector Loader

This block sits between the external active-low reset pin and the processor core. It screens out glitches on the pin by requiring a minimum run of consecutive low samples. When it accepts a reset, it sets the architectural start state: stack pointer, interrupt-level mask, max-mode bit and register bank. While the reset is held, it forces the clock gear to its slowest setting, holds the watchdog pin low with the watchdog armed, and floats the address-latch strobe.

When the pin goes high again, the block reads the three bytes of the start vector, lowest address first, through a single-outstanding byte-read port. It assembles them into a 24-bit program counter and loads it. One cycle later it pulses the start-execute strobe, which releases the core.

If the pin drops during the vector fetch, the fetch is abandoned and the core stays halted until a new reset has been fully qualified. Core registers other than the program counter, stack pointer and status fields are not touched, because the block drives no load strobe for them.

Top module: `boot_reset_seq`

## Requirements
- R1: The reset pin passes through a two-stage synchronizer. A reset is accepted on the 10th (MIN_LOW) consecutive low synchronized sample, which happens when the pin is low across 10 rising clock edges. A shorter low pulse is ignored: no arch_load pulse follows, and a running core stays running (core_halt stays 0).
- R2: Acceptance produces a one-cycle arch_load pulse. During that pulse sp_value is 32'h0000_0100, imask is 3'b111, max_mode is 1 and reg_bank is 3'b000.
- R3: From the arch_load cycle until the pin is seen high again, these hold: gear_div16=1, wdt_hold=1, ale_oe=0, core_halt=1 and rd_req=0.
- R4: After release the block issues exactly three reads, at addresses 24'hFFFF00, 24'hFFFF01 and 24'hFFFF02 in that order, one at a time. rd_req stays high with rd_addr stable until rd_valid is high on a rising edge, which completes that byte.
- R5: pc_load is a one-cycle pulse in the cycle after the edge that completes the third byte. pc_value then equals {byte from FFFF02, byte from FFFF01, byte from FFFF00}.
- R6: cpu_start is a one-cycle pulse in the cycle after pc_load. core_halt is 0 from that cycle on.
- R7: A synchronized low sample during the fetch, or in the pc_load cycle, aborts the boot. rd_req is 0 from the next cycle, no later pc_load or cpu_start follows, and core_halt stays 1 until a new reset is fully qualified. An abort takes priority over a byte that completes on the same edge.
- R8: After power-on reset the outputs are core_halt=1, rd_req=0, ale_oe=1, gear_div16=0 and wdt_hold=0, and no load pulse occurs until a reset is qualified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low, released synchronously |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | 24 | Byte read address |
| rd_valid | input | 1 | Read data valid; a high sample on a rising edge completes the read |
| rd_data | input | 8 | Read data byte |
| arch_load | output | 1 | One-cycle strobe to load stack pointer and status fields |
| sp_value | output | 32 | Stack pointer start value |
| imask | output | 3 | Interrupt-level mask start value |
| max_mode | output | 1 | Max-mode bit start value |
| reg_bank | output | 3 | Register bank start value |
| pc_load | output | 1 | One-cycle strobe to load the program counter |
| pc_value | output | 24 | Assembled start vector |
| cpu_start | output | 1 | One-cycle start-execute strobe |
| core_halt | output | 1 | Core held stopped |
| gear_div16 | output | 1 | Forces the clock gear to divide-by-16 |
| wdt_hold | output | 1 | Drives the watchdog pin low and arms the watchdog |
| ale_oe | output | 1 | Output enable of the address-latch strobe pin (0 = high impedance) |

## Verification
A new reset can arrive on the same edge that completes the last vector byte, or one edge later, while the program-counter load is already in flight. The bench serves the third byte by hand. It drops the pin exactly two cycles before the completing edge, so that the synchronized low and the byte arrive together. Here it expects neither pc_load nor cpu_start. It then repeats the case with the byte one cycle earlier, and expects pc_load but no cpu_start. In both cases the core must stay halted and rd_req must fall, and only a later full-length reset may bring up a correctly assembled vector.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  typedef enum logic [2:0] {
    ST_WAIT  = 3'd0,
    ST_HELD  = 3'd1,
    ST_FETCH = 3'd2,
    ST_LOAD  = 3'd3,
    ST_RUN   = 3'd4
  } boot_state_e;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/rbs_pin_qual.sv
module rbs_pin_qual #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_LOW     = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic clear,
  output logic pin_low,
  output logic accept
);

  localparam int unsigned CNT_W = $clog2(MIN_LOW + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_LOW - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic [CNT_W-1:0]       cnt_q;
  logic [CNT_W-1:0]       cnt_d;

  // metastability chain, idles high like a pulled-up pin
  assign sync_d = {sync_q[SYNC_STAGES-2:0], pin_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= sync_d;
  end

  assign pin_low = ~sync_q[SYNC_STAGES-1];

  // consecutive-low run length, saturating at the acceptance point
  always_comb begin
    cnt_d = cnt_q;
    if (clear || !pin_low)     cnt_d = '0;
    else if (cnt_q != CNT_LAST) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign accept = !clear && pin_low && (cnt_q == CNT_LAST);

  a_r1_accept_needs_run : assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $past(pin_low));

  a_r1_first_low_no_accept : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_low) |-> !accept);

endmodule

// File: rtl/rbs_vec_fetch.sv
module rbs_vec_fetch
  import rbs_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 24,
  parameter logic [ADDR_W-1:0] VEC_BASE = 24'hFFFF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              rd_valid,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              done,
  output logic [ADDR_W-1:0] vector
);

  localparam int unsigned NBYTES = ADDR_W / BYTE_W;
  localparam int unsigned IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NBYTES - 1);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;
  logic             take;

  assign take    = run && rd_valid;
  assign rd_req  = run;
  assign rd_addr = VEC_BASE + ADDR_W'(idx_q);
  assign done    = take && (idx_q == IDX_LAST);

  // byte index: parked at zero whenever the fetch is not running
  always_comb begin
    idx_d = idx_q;
    if (!run)      idx_d = '0;
    else if (take) idx_d = idx_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  // one byte lane per vector byte, little-endian placement
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic              hit;
    logic [BYTE_W-1:0] lane_q;
    logic [BYTE_W-1:0] lane_d;

    assign hit = take && (idx_q == IDX_W'(g));

    always_comb begin
      lane_d = lane_q;
      if (hit) lane_d = rd_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else        lane_q <= lane_d;
    end

    assign vector[g*BYTE_W +: BYTE_W] = lane_q;
  end

  a_r4_addr_held : assert property (@(posedge clk) disable iff (!rst_n)
    (run && !rd_valid) |=> (!run || $stable(rd_addr)));

  a_r4_starts_at_base : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (rd_addr == VEC_BASE));

endmodule

// File: rtl/rbs_ctrl.sv
module rbs_ctrl
  import rbs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin_low,
  input  logic accept,
  input  logic fetch_done,
  output logic fetch_run,
  output logic qual_clear,
  output logic arch_load,
  output logic pc_load,
  output logic cpu_start,
  output logic core_halt,
  output logic gear_div16,
  output logic wdt_hold,
  output logic ale_oe
);

  boot_state_e state_q;
  boot_state_e state_d;
  logic        arch_q, arch_d;
  logic        pcl_q, pcl_d;
  logic        start_q, start_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT:  if (accept) state_d = ST_HELD;
      ST_HELD:  if (!pin_low) state_d = ST_FETCH;
      ST_FETCH: begin
        if (pin_low)         state_d = ST_WAIT;   // abort beats a returning byte
        else if (fetch_done) state_d = ST_LOAD;
      end
      ST_LOAD:  state_d = pin_low ? ST_WAIT : ST_RUN;
      ST_RUN:   if (accept) state_d = ST_HELD;
      default:  state_d = ST_WAIT;
    endcase
  end

  always_comb begin
    arch_d  = (state_q != ST_HELD) && (state_d == ST_HELD);
    pcl_d   = (state_q == ST_FETCH) && (state_d == ST_LOAD);
    start_d = (state_q == ST_LOAD) && (state_d == ST_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      arch_q  <= 1'b0;
      pcl_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      arch_q  <= arch_d;
      pcl_q   <= pcl_d;
      start_q <= start_d;
    end
  end

  assign fetch_run  = (state_q == ST_FETCH);
  assign qual_clear = (state_q == ST_HELD);
  assign arch_load  = arch_q;
  assign pc_load    = pcl_q;
  assign cpu_start  = start_q;
  assign core_halt  = (state_q != ST_RUN);
  assign gear_div16 = (state_q == ST_HELD);
  assign wdt_hold   = (state_q == ST_HELD);
  assign ale_oe     = (state_q != ST_HELD);

  a_r1_arch_single : assert property (@(posedge clk) disable iff (!rst_n)
    arch_load |=> !arch_load);

  a_r5_load_after_last_byte : assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> $past(fetch_done));

  a_r6_start_after_load : assert property (@(posedge clk) disable iff (!rst_n)
    cpu_start |-> $past(pc_load));

  a_r7_abort_stops_fetch : assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_run && pin_low) |=> (!fetch_run && !pc_load));

endmodule

// File: rtl/boot_reset_seq.sv
module boot_reset_seq
  import rbs_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 24,
  parameter logic [ADDR_W-1:0] VEC_BASE    = 24'hFFFF00,
  parameter int unsigned       MIN_LOW     = 10,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter int unsigned       SP_W        = 32,
  parameter logic [SP_W-1:0]   SP_INIT     = 32'h0000_0100,
  parameter logic [2:0]        IMASK_INIT  = 3'b111,
  parameter logic [2:0]        BANK_INIT   = 3'b000
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_pin_n,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              arch_load,
  output logic [SP_W-1:0]   sp_value,
  output logic [2:0]        imask,
  output logic              max_mode,
  output logic [2:0]        reg_bank,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_value,
  output logic              cpu_start,
  output logic              core_halt,
  output logic              gear_div16,
  output logic              wdt_hold,
  output logic              ale_oe
);

  logic [SYNC_STAGES-1:0] por_q;
  logic                   rst_n;
  logic                   pin_low;
  logic                   accept;
  logic                   qual_clear;
  logic                   fetch_run;
  logic                   fetch_done;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) por_q <= '0;
    else        por_q <= {por_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n = por_q[SYNC_STAGES-1];

  rbs_pin_qual #(
    .SYNC_STAGES (SYNC_STAGES),
    .MIN_LOW     (MIN_LOW)
  ) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_n   (rst_pin_n),
    .clear   (qual_clear),
    .pin_low (pin_low),
    .accept  (accept)
  );

  rbs_vec_fetch #(
    .ADDR_W   (ADDR_W),
    .VEC_BASE (VEC_BASE)
  ) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (fetch_run),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .done     (fetch_done),
    .vector   (pc_value)
  );

  rbs_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_low    (pin_low),
    .accept     (accept),
    .fetch_done (fetch_done),
    .fetch_run  (fetch_run),
    .qual_clear (qual_clear),
    .arch_load  (arch_load),
    .pc_load    (pc_load),
    .cpu_start  (cpu_start),
    .core_halt  (core_halt),
    .gear_div16 (gear_div16),
    .wdt_hold   (wdt_hold),
    .ale_oe     (ale_oe)
  );

  assign sp_value = SP_INIT;
  assign imask    = IMASK_INIT;
  assign max_mode = 1'b1;
  assign reg_bank = BANK_INIT;

  a_r3_no_read_while_held : assert property (@(posedge clk) disable iff (!rst_n)
    gear_div16 |-> !rd_req);

  a_r6_start_releases_core : assert property (@(posedge clk) disable iff (!rst_n)
    cpu_start |-> (!core_halt && $past(core_halt)));

endmodule

// File: tb/boot_reset_seq_test.sv
module boot_reset_seq_test;

  localparam logic [23:0] BASE = 24'hFFFF00;

  logic        clk = 1'b0;
  logic        por_n;
  logic        rst_pin_n;
  logic        rd_req;
  logic [23:0] rd_addr;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        arch_load, max_mode, pc_load, cpu_start, core_halt;
  logic        gear_div16, wdt_hold, ale_oe;
  logic [31:0] sp_value;
  logic [2:0]  imask, reg_bank;
  logic [23:0] pc_value;

  always #10 clk = ~clk;

  boot_reset_seq uut (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .arch_load(arch_load), .sp_value(sp_value), .imask(imask), .max_mode(max_mode),
    .reg_bank(reg_bank), .pc_load(pc_load), .pc_value(pc_value), .cpu_start(cpu_start),
    .core_halt(core_halt), .gear_div16(gear_div16), .wdt_hold(wdt_hold), .ale_oe(ale_oe)
  );

  int tests = 0;
  int failed = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fb(input int idx, input int seed);
    return 8'((idx * 37 + seed * 11 + 90) & 255);
  endfunction

  function automatic logic [23:0] exp_pc(input int seed);
    return {fb(2, seed), fb(1, seed), fb(0, seed)};
  endfunction

  // responder + monitor, all at the falling edge
  bit          manual = 0;
  logic        man_valid = 1'b0;
  logic [7:0]  man_data = 8'h00;
  logic        auto_valid = 1'b0;
  logic [7:0]  auto_data = 8'h00;
  int          resp_lat = 0;
  int          resp_cnt = 0;
  int          seed = 0;
  int          arch_cnt = 0, pcl_cnt = 0, start_cnt = 0, halt_cnt = 0, req_cnt = 0;
  int          cyc = 0, last_pcl_cyc = -10;
  logic [23:0] pc_seen = '0;
  logic [23:0] addr_log [8];
  int          n_log = 0;

  assign rd_valid = manual ? man_valid : auto_valid;
  assign rd_data  = manual ? man_data  : auto_data;

  always @(negedge clk) begin
    if (por_n) begin
      if (arch_load) begin
        arch_cnt++;
        n_log = 0;
        chk(sp_value == 32'h100 && imask == 3'b111 && max_mode && reg_bank == 3'b000,
            "R2", {sp_value, imask, max_mode, reg_bank}, {32'h100, 3'b111, 1'b1, 3'b000});
      end
      if (pc_load) begin
        pcl_cnt++;
        pc_seen = pc_value;
        last_pcl_cyc = cyc;
      end
      if (cpu_start) begin
        start_cnt++;
        chk(last_pcl_cyc == cyc - 1 && !core_halt, "R6", cyc - last_pcl_cyc, 1);
      end
      if (core_halt) halt_cnt++;
      if (rd_req) req_cnt++;
    end
    if (manual) begin
      auto_valid = 1'b0;
      resp_cnt = 0;
    end else if (auto_valid) begin
      auto_valid = 1'b0;
      resp_cnt = 0;
    end else if (rd_req) begin
      if (resp_cnt >= resp_lat) begin
        auto_valid = 1'b1;
        auto_data = fb(int'(rd_addr[7:0]), seed);
        if (n_log < 8) addr_log[n_log] = rd_addr;
        n_log++;
      end else resp_cnt++;
    end
    cyc++;
  end

  task automatic pulse(input int w);
    @(negedge clk);
    rst_pin_n = 1'b0;
    repeat (w) @(negedge clk);
    rst_pin_n = 1'b1;
  endtask

  task automatic check_boot(input int s);
    chk(pc_seen == exp_pc(s), "R5", pc_seen, exp_pc(s));
    chk(n_log == 3, "R4", n_log, 3);
    for (int i = 0; i < 3; i++)
      chk(addr_log[i] == BASE + 24'(i), "R4", addr_log[i], BASE + 24'(i));
    chk(!core_halt, "R6", core_halt, 0);
  endtask

  task automatic serve(input int idx);
    while (!(rd_req && rd_addr == BASE + 24'(idx))) @(negedge clk);
    man_valid = 1'b1;
    man_data = fb(idx, seed);
    @(negedge clk);
    man_valid = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      failed++;
      tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    int a0, p0, s0, h0, r0;
    bit acc, was_run;
    por_n = 1'b0;
    rst_pin_n = 1'b1;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    repeat (15) @(negedge clk);

    // R8: power-on state
    chk(core_halt && !rd_req && ale_oe && !gear_div16 && !wdt_hold, "R8",
        {core_halt, rd_req, ale_oe, gear_div16, wdt_hold}, 5'b10100);
    chk(arch_cnt == 0 && pcl_cnt == 0 && start_cnt == 0, "R8", arch_cnt + pcl_cnt + start_cnt, 0);

    // R1/R4/R5/R6: pulse width sweep across read latencies
    for (int lat = 0; lat < 4; lat++) begin
      for (int w = 1; w <= 14; w++) begin
        resp_lat = lat;
        seed++;
        was_run = !core_halt;
        a0 = arch_cnt; p0 = pcl_cnt; s0 = start_cnt; h0 = halt_cnt;
        pulse(w);
        repeat (45) @(negedge clk);
        acc = (w >= 10);
        chk((arch_cnt - a0) == int'(acc), "R1", arch_cnt - a0, acc);
        if (acc) begin
          chk(pcl_cnt - p0 == 1, "R5", pcl_cnt - p0, 1);
          chk(start_cnt - s0 == 1, "R6", start_cnt - s0, 1);
          check_boot(seed);
        end else begin
          chk(pcl_cnt == p0 && start_cnt == s0, "R1", pcl_cnt - p0, 0);
          if (was_run) chk(halt_cnt == h0, "R1", halt_cnt - h0, 0);
          else         chk(core_halt, "R8", core_halt, 1);
        end
      end
    end

    // R3: side effects while held
    resp_lat = 1;
    seed++;
    r0 = req_cnt;
    @(negedge clk);
    rst_pin_n = 1'b0;
    repeat (16) @(negedge clk);
    chk(gear_div16 && wdt_hold && !ale_oe && core_halt && !rd_req, "R3",
        {gear_div16, wdt_hold, ale_oe, core_halt, rd_req}, 5'b11010);
    repeat (20) @(negedge clk);
    chk(req_cnt == r0, "R3", req_cnt - r0, 0);
    chk(gear_div16 && wdt_hold && !ale_oe, "R3", {gear_div16, wdt_hold, ale_oe}, 3'b110);
    rst_pin_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(!gear_div16 && !wdt_hold && ale_oe, "R3", {gear_div16, wdt_hold, ale_oe}, 3'b001);
    check_boot(seed);

    // R7: abort in the middle of the fetch
    resp_lat = 3;
    seed++;
    pulse(12);
    while (!(rd_req && rd_addr == BASE + 24'd1)) @(negedge clk);
    a0 = arch_cnt; p0 = pcl_cnt; s0 = start_cnt;
    rst_pin_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_pin_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(pcl_cnt == p0 && start_cnt == s0 && arch_cnt == a0, "R7", pcl_cnt - p0, 0);
    chk(core_halt && !rd_req, "R7", {core_halt, rd_req}, 2'b10);
    seed++;
    pulse(12);
    repeat (45) @(negedge clk);
    chk(start_cnt - s0 == 1, "R7", start_cnt - s0, 1);
    check_boot(seed);

    // R7: abort lands on the edge that completes the third byte
    manual = 1;
    seed++;
    pulse(12);
    serve(0);
    serve(1);
    while (!(rd_req && rd_addr == BASE + 24'd2)) @(negedge clk);
    p0 = pcl_cnt; s0 = start_cnt;
    rst_pin_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    man_valid = 1'b1;
    man_data = fb(2, seed);
    @(negedge clk);
    man_valid = 1'b0;
    rst_pin_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(pcl_cnt == p0, "R7", pcl_cnt - p0, 0);
    chk(start_cnt == s0 && core_halt && !rd_req, "R7", start_cnt - s0, 0);

    // R7: abort lands in the program-counter load cycle
    seed++;
    pulse(12);
    serve(0);
    serve(1);
    while (!(rd_req && rd_addr == BASE + 24'd2)) @(negedge clk);
    p0 = pcl_cnt; s0 = start_cnt;
    rst_pin_n = 1'b0;
    @(negedge clk);
    man_valid = 1'b1;
    man_data = fb(2, seed);
    @(negedge clk);
    man_valid = 1'b0;
    @(negedge clk);
    rst_pin_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(pcl_cnt - p0 == 1, "R7", pcl_cnt - p0, 1);
    chk(start_cnt == s0 && core_halt, "R7", start_cnt - s0, 0);

    // recovery after both aborts
    manual = 0;
    resp_lat = 0;
    seed++;
    pulse(10);
    repeat (45) @(negedge clk);
    check_boot(seed);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

endmodule